// File: doc/BRIEF.md
# Legacy Mode-Port Autoswitch Interrupt Trap

This block snoops host I/O writes aimed at the mode control ports of older mono and color display adapters. Firmware enables the trap for each port on its own. When an enabled port is written, the block raises a non-maskable interrupt request. The firmware handler can then reprogram the display to suit whatever the legacy software expected. A global interrupt enable bit sits in front of both per-port enables.

The enable bits live in two indexed registers behind a sequencer-style index/data port pair. The index port is at 3C4h and the data port is at 3C5h. The interrupt request is a level. It stays high until the handler reads a status register through the same data port. That status register reports which watched port caused the request, and reading it clears the request. A third bit in the second control register selects legacy adapter emulation. This bit is only held and brought out. It does not gate the trap.

Top module: `autosw_nmi_trap`

## Requirements
- R1: After reset, nmi_o, trig_src_o and emu_o are 0. The index register and both control registers read back as 0.
- R2: A write to port 3C4h loads the index, and a read of 3C4h returns it. Through port 3C5h, index 07h reads and writes control register A, and index 08h reads and writes control register B, all 8 bits. Any other index except the status index reads 0, and writes to it are dropped.
- R3: If control A bit 6 and control B bit 1 are both set, a host write to port 3B8h sets nmi_o and trig_src_o bit 0 in the cycle after the write.
- R4: If control A bit 6 and control B bit 2 are both set, a host write to port 3D8h sets nmi_o and trig_src_o bit 1 in the cycle after the write.
- R5: While control A bit 6 is clear, writes to 3B8h and 3D8h leave nmi_o and trig_src_o unchanged.
- R6: Each watched port is gated only by its own control B bit. With only bit 1 set, a write to 3D8h does not trigger. With only bit 2 set, a write to 3B8h does not trigger.
- R7: A read of 3C5h with index 1Bh returns the status byte, with bit 0 for mono and bit 1 for color and the upper bits 0. From the next cycle, nmi_o and all status bits are 0. Writes to index 1Bh have no effect.
- R8: A trigger that arrives while a request is pending sets its own status bit, and nmi_o stays high without dropping.
- R9: Host reads of 3B8h or 3D8h, and writes to any other port, never raise nmi_o.
- R10: A pending request survives the clearing of control A bit 6 and of the control B enable bits. Only the status read clears it.
- R11: emu_o follows control B bit 0. That bit neither enables nor blocks a trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 16 | Host I/O address |
| io_wdata_i | input | 8 | Host write data |
| io_wr_i | input | 1 | Host write strobe, one cycle per access |
| io_rd_i | input | 1 | Host read strobe, one cycle per access |
| io_rdata_o | output | 8 | Read data, valid in the cycle io_rd_i is high |
| nmi_o | output | 1 | Non-maskable interrupt request level |
| trig_src_o | output | 2 | Pending trigger sources: bit 0 mono, bit 1 color |
| emu_o | output | 1 | Legacy adapter emulation select (control B bit 0) |

## Verification
A wrong enable bit in either control register shows up right away through 3C5h readback. It also shows as a missing or spurious nmi_o one cycle after the next write to a watched port. A corrupted status or pending flag shows on trig_src_o and nmi_o in the very next cycle. Those two outputs are compared after every access. A clear that goes wrong leaves nmi_o high in the cycle after the status read, and the bench checks that cycle explicitly.

// File: rtl/autosw_pkg.sv
package autosw_pkg;
  localparam int NUM_SRC = 2;
  localparam int AW      = 16;
  localparam int DW      = 8;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  // watched port per source, bit order matches the status byte
  function automatic logic [AW-1:0] src_port(input int idx);
    case (idx)
      0:       src_port = 16'h03B8;
      default: src_port = 16'h03D8;
    endcase
  endfunction
endpackage

// File: rtl/autosw_regs.sv
module autosw_regs
  import autosw_pkg::*;
#(
  parameter logic [AW-1:0] IDX_PORT = 16'h03C4,
  parameter logic [AW-1:0] DAT_PORT = 16'h03C5,
  parameter logic [DW-1:0] IDX_CTLA = 8'h07,
  parameter logic [DW-1:0] IDX_CTLB = 8'h08,
  parameter logic [DW-1:0] IDX_STAT = 8'h1B,
  parameter int            GEN_BIT  = 6,
  parameter int            EMU_BIT  = 0,
  parameter int            SRC_LSB  = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  src_vec_t      status_i,
  output logic [DW-1:0] rdata_o,
  output logic          stat_clr_o,
  output logic          gen_en_o,
  output src_vec_t      src_en_o,
  output logic          emu_o
);
  localparam int PAD = DW - NUM_SRC;

  logic [DW-1:0] idx_q, ctla_q, ctlb_q;
  logic          idx_wr, dat_wr, dat_rd, idx_rd;

  assign idx_wr = wr_i && (addr_i == IDX_PORT);
  assign dat_wr = wr_i && (addr_i == DAT_PORT);
  assign idx_rd = rd_i && (addr_i == IDX_PORT);
  assign dat_rd = rd_i && (addr_i == DAT_PORT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      ctla_q <= '0;
      ctlb_q <= '0;
    end else begin
      if (idx_wr) idx_q <= wdata_i;
      if (dat_wr && idx_q == IDX_CTLA) ctla_q <= wdata_i;
      if (dat_wr && idx_q == IDX_CTLB) ctlb_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (idx_rd) begin
      rdata_o = idx_q;
    end else if (dat_rd) begin
      if (idx_q == IDX_CTLA)      rdata_o = ctla_q;
      else if (idx_q == IDX_CTLB) rdata_o = ctlb_q;
      else if (idx_q == IDX_STAT) rdata_o = {{PAD{1'b0}}, status_i};
    end
  end

  assign stat_clr_o = dat_rd && (idx_q == IDX_STAT);
  assign gen_en_o   = ctla_q[GEN_BIT];
  assign emu_o      = ctlb_q[EMU_BIT];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_en
    assign src_en_o[i] = ctlb_q[SRC_LSB+i];
  end

  // control registers only move on a data-port write
  AST_CTL_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dat_wr |=> ($stable(ctla_q) && $stable(ctlb_q))); // R2
endmodule

// File: rtl/autosw_snoop.sv
module autosw_snoop
  import autosw_pkg::*;
(
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic          gen_en_i,
  input  src_vec_t      src_en_i,
  output src_vec_t      hit_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign hit_o[i] = wr_i && gen_en_i && src_en_i[i] && (addr_i == src_port(i));
  end

  AST_HIT_SINGLE: assert final ($onehot0(hit_o)); // R9
endmodule

// File: rtl/autosw_status.sv
module autosw_status
  import autosw_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t hit_i,
  input  logic     clr_i,
  output src_vec_t status_o,
  output logic     nmi_o
);
  src_vec_t status_q;
  logic     nmi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      nmi_q    <= 1'b0;
    end else begin
      status_q <= (clr_i ? '0 : status_q) | hit_i;
      nmi_q    <= (nmi_q && !clr_i) || (|hit_i);
    end
  end

  assign status_o = status_q;
  assign nmi_o    = nmi_q;

  AST_NMI_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_q == (status_q != '0)); // R3
  AST_HIT_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_i) |=> nmi_q); // R4
  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_q && !clr_i) |=> nmi_q); // R8
  AST_CLR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && hit_i == '0) |=> (!nmi_q && status_q == '0)); // R7
endmodule

// File: rtl/autosw_nmi_trap.sv
module autosw_nmi_trap
  import autosw_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [15:0]   io_addr_i,
  input  logic [7:0]    io_wdata_i,
  input  logic          io_wr_i,
  input  logic          io_rd_i,
  output logic [7:0]    io_rdata_o,
  output logic          nmi_o,
  output logic [1:0]    trig_src_o,
  output logic          emu_o
);
  src_vec_t status, src_en, hit;
  logic     stat_clr, gen_en;

  autosw_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (io_addr_i),
    .wdata_i    (io_wdata_i),
    .wr_i       (io_wr_i),
    .rd_i       (io_rd_i),
    .status_i   (status),
    .rdata_o    (io_rdata_o),
    .stat_clr_o (stat_clr),
    .gen_en_o   (gen_en),
    .src_en_o   (src_en),
    .emu_o      (emu_o)
  );

  autosw_snoop u_snoop (
    .wr_i     (io_wr_i),
    .addr_i   (io_addr_i),
    .gen_en_i (gen_en),
    .src_en_i (src_en),
    .hit_o    (hit)
  );

  autosw_status u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .clr_i    (stat_clr),
    .status_o (status),
    .nmi_o    (nmi_o)
  );

  assign trig_src_o = status;

  AST_READ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_wr_i && !nmi_o) |=> !nmi_o); // R9
  AST_GLOBAL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gen_en && !nmi_o) |=> !nmi_o); // R5
  AST_SRC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_clr && trig_src_o[0]) |=> trig_src_o[0]); // R10
endmodule

// File: tb/autosw_nmi_trap_test.sv
module autosw_nmi_trap_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata;
  logic        nmi, emu;
  logic [1:0]  src;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  localparam logic [15:0] P_IDX = 16'h03C4, P_DAT = 16'h03C5;
  localparam logic [15:0] P_MONO = 16'h03B8, P_COLOR = 16'h03D8;

  always #2.5 clk = ~clk;

  autosw_nmi_trap uut (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_wdata_i(wdata),
    .io_wr_i(wr), .io_rd_i(rd), .io_rdata_o(rdata), .nmi_o(nmi),
    .trig_src_o(src), .emu_o(emu)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
    io_write(P_IDX, idx);
    io_write(P_DAT, d);
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
    io_write(P_IDX, idx);
    io_read(P_DAT, d);
  endtask

  task automatic clear_and_check(input string req, input logic [7:0] exp);
    logic [7:0] d;
    reg_rd(8'h1B, d);
    check(req, d, exp);
    check(req, {7'b0, nmi}, 8'h00);
    check(req, {6'b0, src}, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1", {7'b0, nmi}, 0);
    check("R1", {6'b0, src}, 0);
    check("R1", {7'b0, emu}, 0);
    io_read(P_IDX, d); check("R1", d, 0);
    io_read(P_DAT, d); check("R1", d, 0);
    reg_rd(8'h08, d);  check("R1", d, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    reg_wr(8'h07, 8'h5A); reg_rd(8'h07, d); check("R2", d, 8'h5A);
    reg_wr(8'h08, 8'hA0); reg_rd(8'h08, d); check("R2", d, 8'hA0);
    reg_wr(8'h03, 8'hFF); reg_rd(8'h03, d); check("R2", d, 8'h00);
    io_read(P_IDX, d); check("R2", d, 8'h03);
    reg_rd(8'h07, d); check("R2", d, 8'h5A);
    reg_rd(8'h08, d); check("R2", d, 8'hA0);
  endtask

  task automatic t_mono();
    reg_wr(8'h07, 8'h40); reg_wr(8'h08, 8'h06);
    io_write(P_MONO, 8'h29);
    check("R3", {7'b0, nmi}, 1);
    check("R3", {6'b0, src}, 8'h01);
    clear_and_check("R7", 8'h01);
  endtask

  task automatic t_color();
    io_write(P_COLOR, 8'h09);
    check("R4", {7'b0, nmi}, 1);
    check("R4", {6'b0, src}, 8'h02);
    clear_and_check("R7", 8'h02);
  endtask

  task automatic t_global_off();
    reg_wr(8'h07, 8'hBF);
    io_write(P_MONO, 8'h01);
    io_write(P_COLOR, 8'h01);
    check("R5", {7'b0, nmi}, 0);
    check("R5", {6'b0, src}, 0);
    reg_wr(8'h07, 8'h40);
  endtask

  task automatic t_per_port();
    reg_wr(8'h08, 8'h02);
    io_write(P_COLOR, 8'h01);
    check("R6", {7'b0, nmi}, 0);
    io_write(P_MONO, 8'h01);
    check("R6", {6'b0, src}, 8'h01);
    clear_and_check("R6", 8'h01);
    reg_wr(8'h08, 8'h04);
    io_write(P_MONO, 8'h01);
    check("R6", {7'b0, nmi}, 0);
    io_write(P_COLOR, 8'h01);
    check("R6", {6'b0, src}, 8'h02);
    clear_and_check("R6", 8'h02);
  endtask

  task automatic t_status_misc();
    logic [7:0] d;
    reg_rd(8'h1B, d); check("R7", d, 8'h00);
    reg_wr(8'h1B, 8'h03);
    check("R7", {7'b0, nmi}, 0);
    check("R7", {6'b0, src}, 0);
  endtask

  task automatic t_pending();
    reg_wr(8'h08, 8'h06);
    io_write(P_MONO, 8'h01);
    check("R8", {7'b0, nmi}, 1);
    @(negedge clk); addr = P_COLOR; wr = 1'b1;
    #1 check("R8", {7'b0, nmi}, 1);
    @(negedge clk); wr = 1'b0;
    check("R8", {7'b0, nmi}, 1);
    check("R8", {6'b0, src}, 8'h03);
    clear_and_check("R8", 8'h03);
  endtask

  task automatic t_reads();
    logic [7:0] d;
    io_read(P_MONO, d);
    io_read(P_COLOR, d);
    check("R9", {7'b0, nmi}, 0);
    io_write(16'h03B9, 8'h01);
    io_write(16'h02D8, 8'h01);
    check("R9", {7'b0, nmi}, 0);
    check("R9", {6'b0, src}, 0);
  endtask

  task automatic t_hold();
    io_write(P_MONO, 8'h01);
    reg_wr(8'h07, 8'h00);
    reg_wr(8'h08, 8'h00);
    check("R10", {7'b0, nmi}, 1);
    check("R10", {6'b0, src}, 8'h01);
    clear_and_check("R10", 8'h01);
  endtask

  task automatic t_emu();
    reg_wr(8'h07, 8'h40);
    reg_wr(8'h08, 8'h01);
    check("R11", {7'b0, emu}, 1);
    io_write(P_MONO, 8'h01);
    io_write(P_COLOR, 8'h01);
    check("R11", {7'b0, nmi}, 0);
    reg_wr(8'h08, 8'h06);
    check("R11", {7'b0, emu}, 0);
    io_write(P_MONO, 8'h01);
    check("R11", {7'b0, nmi}, 1);
    clear_and_check("R11", 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_mono();
    t_color();
    t_global_off();
    t_per_port();
    t_status_misc();
    t_pending();
    t_reads();
    reg_wr(8'h08, 8'h06);
    t_hold();
    t_emu();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule